// File: doc/BRIEF.md
# Power-Sourcing Port Current Supervisor

This block decides whether a single power-sourcing Ethernet port is powered. Each clock it may receive a current sample in milliamps. It also receives an impedance sample in kilohms and a flag from detection that says a valid load is attached. A 1 ms tick input drives every timer, so time can be scaled down freely. A host supplies the thresholds and periods as plain configuration inputs.

Once enabled, the port enters a startup phase. During that phase a bounded inrush is tolerated and overload qualification is held off. The port then runs powered. Two faults are time-qualified independently. The first is an overload, where current stays above a cut level. The second is a missing load. In DC mode that means current below a minimum. In AC mode it means impedance above a high limit. Each fault leads to its own shutdown state. Each shutdown state waits its own recovery period and then retries. An active-low global disable and a host enable override everything.

Top module: `poe_port_supervisor`

## Requirements
- R1: With `disableN`, `hostEnable` and `loadPresent` all high, a port in the off state (status code 0) powers up: `portEn` goes high and the status code reads 1 (powered) within two clocks.
- R2: During the startup window of `cfgInrushMs` ticks, a current above `cfgCutMa` but not above `cfgLimMa` does not trip. Overload qualification starts only when the window ends, so a persistent such current trips after about `cfgInrushMs + cfgOvlMs` ticks.
- R3: During startup, a sample above `cfgLimMa` moves the port to overload-off (status code 2) within three clocks, without waiting for any tick.
- R4: While powered, a current strictly above `cfgCutMa` that persists for `cfgOvlMs` ticks leads to overload-off (status code 2). A current equal to `cfgCutMa` never trips.
- R5: A single sample that ends a violation restarts the qualification time from zero, so only uninterrupted violations trip the port.
- R6: In DC mode (`cfgAcMode` = 0), a current whose doubled value is below `cfgMinHalfMa` (the minimum in 0.5 mA steps, 15 = 7.5 mA) and that persists for `cfgHoldMs` ticks leads to no-load-off (status code 3). Currents whose doubled value is at or above the minimum keep power.
- R7: In AC mode (`cfgAcMode` = 1), an impedance strictly above `cfgZacCutKohm` that persists for `cfgHoldMs` ticks leads to no-load-off (status code 3). In this mode the current does not take part in the no-load test.
- R8: After overload-off, the port is powered again after `cfgOvlRecMs` ticks.
- R9: After no-load-off, the port is powered again after `cfgUdlRecMs` ticks.
- R10: When `disableN` is low, `portEn` is low in the same cycle. From the next clock the status code is 0, whatever the prior state, and it stays 0 while the disable is held.
- R11: With `hostEnable` low, a powered port goes to off (status 0). With `loadPresent` low, an off port never powers.
- R12: `shutEvent` is high for exactly one clock on each entry into overload-off or no-load-off. It does not pulse for a switch-off caused by an enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickMs | input | 1 | One-cycle pulse per millisecond |
| sampleValid | input | 1 | Current and impedance samples are valid this cycle |
| sampleMa | input | 10 | Port current in mA |
| sampleZacKohm | input | 12 | Measured port impedance in kΩ |
| loadPresent | input | 1 | Detection reports a valid load |
| disableN | input | 1 | Active-low global port disable |
| hostEnable | input | 1 | Host enable for this port |
| cfgAcMode | input | 1 | 1 selects the impedance-based no-load test |
| cfgCutMa | input | 10 | Overload cut level in mA |
| cfgLimMa | input | 10 | Startup inrush ceiling in mA |
| cfgMinHalfMa | input | 11 | No-load minimum in 0.5 mA units |
| cfgZacCutKohm | input | 12 | AC no-load impedance limit in kΩ |
| cfgOvlMs | input | 13 | Overload qualification time in ticks |
| cfgHoldMs | input | 13 | No-load qualification time in ticks |
| cfgInrushMs | input | 13 | Startup window in ticks |
| cfgOvlRecMs | input | 13 | Overload recovery period in ticks |
| cfgUdlRecMs | input | 13 | No-load recovery period in ticks |
| portEn | output | 1 | Port power switch enable |
| statusCode | output | 2 | 0 off, 1 powered, 2 overload-off, 3 no-load-off |
| shutEvent | output | 1 | One-cycle pulse on each fault shutdown |

## Verification
Some properties are checked on every clock. These are the single-cycle width of the shutdown pulse, the move to off that follows a global disable, the rule that a startup with no over-limit sample never lands in overload-off, the fact that a firing overload qualifier always causes the overload shutdown, and the steps of the qualification counters, which move by at most one tick. Other behaviours take a whole scenario and are left to the bench. These are the tick counts to a trip and to a retry, the restart of qualification after a single clean sample, and the exact threshold boundaries in both DC and AC mode. The bench shows them by sweeping thresholds, currents, impedances and periods over a small scaled configuration and a run at the default settings.

// File: rtl/poe_sup_pkg.sv
package poe_sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_ON    = 3'd2,
    ST_OVL   = 3'd3,
    ST_UDL   = 3'd4
  } portState_t;

  typedef enum logic [1:0] {
    PH_INRUSH = 2'd0,
    PH_OVLREC = 2'd1,
    PH_UDLREC = 2'd2
  } phaseSel_t;

  typedef enum logic [1:0] {
    STAT_OFF     = 2'd0,
    STAT_POWERED = 2'd1,
    STAT_OVL     = 2'd2,
    STAT_UDL     = 2'd3
  } status_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      clrPhase;
    logic      ovlArm;
    logic      udlArm;
    phaseSel_t phaseSel;
  } dpCtrl_t;

  // qualified flags from datapath to control
  typedef struct packed {
    logic ovlTrip;
    logic udlTrip;
    logic inrushHigh;
    logic phaseDone;
  } dpFlags_t;

  // suggested host settings
  localparam int DEF_CUT_MA      = 680;
  localparam int DEF_LIM_MA      = 750;
  localparam int DEF_MIN_HALF_MA = 15;
  localparam int DEF_ZAC_KOHM    = 1980;
  localparam int DEF_OVL_MS      = 50;
  localparam int DEF_HOLD_MS     = 350;
  localparam int DEF_INRUSH_MS   = 50;
  localparam int DEF_OVLREC_MS   = 5000;
  localparam int DEF_UDLREC_MS   = 1000;

endpackage

// File: rtl/poe_sup_qual.sv
module poe_sup_qual #(
  parameter int TIME_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              cond,
  input  logic              tick,
  input  logic [TIME_W-1:0] limitMs,
  output logic              trip
);

  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic [TIME_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!arm || !cond) begin
      cnt <= '0;
    end else if (tick && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign trip = arm && cond && (cnt >= limitMs);

  // R5: the qualification time advances at most one tick per clock
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/poe_sup_datapath.sv
module poe_sup_datapath
  import poe_sup_pkg::*;
#(
  parameter int CUR_W  = 10,
  parameter int ZAC_W  = 12,
  parameter int TIME_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic              sampleValid,
  input  logic [CUR_W-1:0]  sampleMa,
  input  logic [ZAC_W-1:0]  sampleZacKohm,
  input  logic              cfgAcMode,
  input  logic [CUR_W-1:0]  cfgCutMa,
  input  logic [CUR_W-1:0]  cfgLimMa,
  input  logic [CUR_W:0]    cfgMinHalfMa,
  input  logic [ZAC_W-1:0]  cfgZacCutKohm,
  input  logic [TIME_W-1:0] cfgOvlMs,
  input  logic [TIME_W-1:0] cfgHoldMs,
  input  logic [TIME_W-1:0] cfgInrushMs,
  input  logic [TIME_W-1:0] cfgOvlRecMs,
  input  logic [TIME_W-1:0] cfgUdlRecMs,
  input  dpCtrl_t           dpCtrl,
  output dpFlags_t          dpFlags
);

  localparam int NUM_QUAL = 2;
  localparam logic [TIME_W-1:0] PH_MAX = '1;

  logic ovlCond;
  logic udlCond;
  logic inrushHigh;
  logic [CUR_W:0] doubledMa;

  assign doubledMa = {sampleMa, 1'b0};

  // sample-held violation flags; a clean sample clears them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovlCond    <= 1'b0;
      udlCond    <= 1'b0;
      inrushHigh <= 1'b0;
    end else if (sampleValid) begin
      ovlCond    <= (sampleMa > cfgCutMa);
      inrushHigh <= (sampleMa > cfgLimMa);
      udlCond    <= cfgAcMode ? (sampleZacKohm > cfgZacCutKohm)
                              : (doubledMa < cfgMinHalfMa);
    end
  end

  // two independent qualifiers: index 0 overload, index 1 no-load
  logic [NUM_QUAL-1:0]              qArm;
  logic [NUM_QUAL-1:0]              qCond;
  logic [NUM_QUAL-1:0][TIME_W-1:0]  qLimit;
  logic [NUM_QUAL-1:0]              qTrip;

  assign qArm   = {dpCtrl.udlArm, dpCtrl.ovlArm};
  assign qCond  = {udlCond, ovlCond};
  assign qLimit = {cfgHoldMs, cfgOvlMs};

  for (genvar q = 0; q < NUM_QUAL; q++) begin : g_qual
    poe_sup_qual #(.TIME_W(TIME_W)) i_qual (
      .clk    (clk),
      .rstN   (rstN),
      .arm    (qArm[q]),
      .cond   (qCond[q]),
      .tick   (tickMs),
      .limitMs(qLimit[q]),
      .trip   (qTrip[q])
    );
  end

  // phase timer: startup window and both recovery periods
  logic [TIME_W-1:0] phaseCnt;
  logic [TIME_W-1:0] phaseTarget;

  always_comb begin
    unique case (dpCtrl.phaseSel)
      PH_OVLREC: phaseTarget = cfgOvlRecMs;
      PH_UDLREC: phaseTarget = cfgUdlRecMs;
      default:   phaseTarget = cfgInrushMs;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (dpCtrl.clrPhase) begin
      phaseCnt <= '0;
    end else if (tickMs && (phaseCnt != PH_MAX)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign dpFlags.ovlTrip    = qTrip[0];
  assign dpFlags.udlTrip    = qTrip[1];
  assign dpFlags.inrushHigh = inrushHigh;
  assign dpFlags.phaseDone  = (phaseCnt >= phaseTarget);

  // R8/R9: the phase timer never goes backwards unless cleared
  a_r8_phase_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.clrPhase |=> (phaseCnt >= $past(phaseCnt)));

endmodule

// File: rtl/poe_sup_ctrl.sv
module poe_sup_ctrl
  import poe_sup_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     disableN,
  input  logic     hostEnable,
  input  logic     loadPresent,
  input  dpFlags_t dpFlags,
  output dpCtrl_t  dpCtrl,
  output logic     powered,
  output status_t  status,
  output logic     shutEvent
);

  portState_t state;
  portState_t nextState;

  always_comb begin
    nextState = state;
    if (!disableN) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (hostEnable && loadPresent) nextState = ST_START;
        end
        ST_START: begin
          if (!hostEnable)              nextState = ST_OFF;
          else if (dpFlags.inrushHigh)  nextState = ST_OVL;
          else if (dpFlags.phaseDone)   nextState = ST_ON;
        end
        ST_ON: begin
          if (!hostEnable)              nextState = ST_OFF;
          else if (dpFlags.ovlTrip)     nextState = ST_OVL;
          else if (dpFlags.udlTrip)     nextState = ST_UDL;
        end
        ST_OVL, ST_UDL: begin
          if (!hostEnable || dpFlags.phaseDone) nextState = ST_OFF;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OFF;
      shutEvent <= 1'b0;
    end else begin
      state     <= nextState;
      shutEvent <= (nextState != state) &&
                   ((nextState == ST_OVL) || (nextState == ST_UDL));
    end
  end

  always_comb begin
    dpCtrl.clrPhase = (nextState != state);
    dpCtrl.ovlArm   = (state == ST_ON);
    dpCtrl.udlArm   = (state == ST_ON);
    unique case (state)
      ST_OVL:  dpCtrl.phaseSel = PH_OVLREC;
      ST_UDL:  dpCtrl.phaseSel = PH_UDLREC;
      default: dpCtrl.phaseSel = PH_INRUSH;
    endcase
  end

  assign powered = (state == ST_START) || (state == ST_ON);

  always_comb begin
    unique case (state)
      ST_START, ST_ON: status = STAT_POWERED;
      ST_OVL:          status = STAT_OVL;
      ST_UDL:          status = STAT_UDL;
      default:         status = STAT_OFF;
    endcase
  end

  // R10: a global disable always lands in off
  a_r10_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    !disableN |=> (state == ST_OFF));

  // R2: no overload shutdown from startup unless the inrush ceiling was exceeded
  a_r2_inrush_masked: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_START) && !dpFlags.inrushHigh) |=> (state != ST_OVL));

  // R4: a fired overload qualifier while powered leads to overload-off
  a_r4_overload_trip: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ON) && dpFlags.ovlTrip && disableN && hostEnable) |=> (state == ST_OVL));

  // R12: the shutdown pulse lasts one clock and coincides with a shutdown state
  a_r12_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    shutEvent |=> !shutEvent);

  a_r12_pulse_state: assert property (@(posedge clk) disable iff (!rstN)
    shutEvent |-> ((state == ST_OVL) || (state == ST_UDL)));

endmodule

// File: rtl/poe_port_supervisor.sv
module poe_port_supervisor
  import poe_sup_pkg::*;
#(
  parameter int CUR_W  = 10,
  parameter int ZAC_W  = 12,
  parameter int TIME_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickMs,
  input  logic              sampleValid,
  input  logic [CUR_W-1:0]  sampleMa,
  input  logic [ZAC_W-1:0]  sampleZacKohm,
  input  logic              loadPresent,
  input  logic              disableN,
  input  logic              hostEnable,
  input  logic              cfgAcMode,
  input  logic [CUR_W-1:0]  cfgCutMa,
  input  logic [CUR_W-1:0]  cfgLimMa,
  input  logic [CUR_W:0]    cfgMinHalfMa,
  input  logic [ZAC_W-1:0]  cfgZacCutKohm,
  input  logic [TIME_W-1:0] cfgOvlMs,
  input  logic [TIME_W-1:0] cfgHoldMs,
  input  logic [TIME_W-1:0] cfgInrushMs,
  input  logic [TIME_W-1:0] cfgOvlRecMs,
  input  logic [TIME_W-1:0] cfgUdlRecMs,
  output logic              portEn,
  output logic [1:0]        statusCode,
  output logic              shutEvent
);

  dpCtrl_t  dpCtrl;
  dpFlags_t dpFlags;
  logic     powered;
  status_t  status;

  poe_sup_datapath #(
    .CUR_W (CUR_W),
    .ZAC_W (ZAC_W),
    .TIME_W(TIME_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .tickMs       (tickMs),
    .sampleValid  (sampleValid),
    .sampleMa     (sampleMa),
    .sampleZacKohm(sampleZacKohm),
    .cfgAcMode    (cfgAcMode),
    .cfgCutMa     (cfgCutMa),
    .cfgLimMa     (cfgLimMa),
    .cfgMinHalfMa (cfgMinHalfMa),
    .cfgZacCutKohm(cfgZacCutKohm),
    .cfgOvlMs     (cfgOvlMs),
    .cfgHoldMs    (cfgHoldMs),
    .cfgInrushMs  (cfgInrushMs),
    .cfgOvlRecMs  (cfgOvlRecMs),
    .cfgUdlRecMs  (cfgUdlRecMs),
    .dpCtrl       (dpCtrl),
    .dpFlags      (dpFlags)
  );

  poe_sup_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .disableN   (disableN),
    .hostEnable (hostEnable),
    .loadPresent(loadPresent),
    .dpFlags    (dpFlags),
    .dpCtrl     (dpCtrl),
    .powered    (powered),
    .status     (status),
    .shutEvent  (shutEvent)
  );

  // the global disable cuts power without waiting for a clock edge
  assign portEn     = powered && disableN;
  assign statusCode = status;

endmodule

// File: tb/test_poe_port_supervisor.sv
module test_poe_port_supervisor;
  import poe_sup_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickMs;
  logic        sampleValid;
  logic [9:0]  sampleMa;
  logic [11:0] sampleZacKohm;
  logic        loadPresent, disableN, hostEnable, cfgAcMode;
  logic [9:0]  cfgCutMa, cfgLimMa;
  logic [10:0] cfgMinHalfMa;
  logic [11:0] cfgZacCutKohm;
  logic [12:0] cfgOvlMs, cfgHoldMs, cfgInrushMs, cfgOvlRecMs, cfgUdlRecMs;
  logic        portEn;
  logic [1:0]  statusCode;
  logic        shutEvent;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tickTotal = 0;
  int divCnt = 0;
  int evtSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poe_port_supervisor i_poe_port_supervisor (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .sampleValid(sampleValid),
    .sampleMa(sampleMa), .sampleZacKohm(sampleZacKohm), .loadPresent(loadPresent),
    .disableN(disableN), .hostEnable(hostEnable), .cfgAcMode(cfgAcMode),
    .cfgCutMa(cfgCutMa), .cfgLimMa(cfgLimMa), .cfgMinHalfMa(cfgMinHalfMa),
    .cfgZacCutKohm(cfgZacCutKohm), .cfgOvlMs(cfgOvlMs), .cfgHoldMs(cfgHoldMs),
    .cfgInrushMs(cfgInrushMs), .cfgOvlRecMs(cfgOvlRecMs), .cfgUdlRecMs(cfgUdlRecMs),
    .portEn(portEn), .statusCode(statusCode), .shutEvent(shutEvent)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (shutEvent) evtSeen++;
    divCnt++;
    tickMs = (divCnt % TICK_DIV == 0);
    if (tickMs) tickTotal++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
  endtask

  task automatic expectRange(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic waitStatus(int target, int maxCycles, output int ticks,
                            output int cyc, output bit hit);
    int t0 = tickTotal;
    hit = 1'b0; cyc = 0;
    for (int i = 0; i < maxCycles; i++) begin
      step(); cyc++;
      if (statusCode == 2'(target)) begin hit = 1'b1; break; end
    end
    ticks = tickTotal - t0;
  endtask

  task automatic waitTicks(int n);
    int t0 = tickTotal;
    while (tickTotal < t0 + n) step();
  endtask

  task automatic smallCfg();
    cfgAcMode = 1'b0; cfgCutMa = 10'd680; cfgLimMa = 10'd750;
    cfgMinHalfMa = 11'd15; cfgZacCutKohm = 12'd1980;
    cfgOvlMs = 13'd4; cfgHoldMs = 13'd6; cfgInrushMs = 13'd3;
    cfgOvlRecMs = 13'd10; cfgUdlRecMs = 13'd5;
  endtask

  task automatic resetDut();
    rstN = 1'b0; hostEnable = 1'b0; loadPresent = 1'b0; disableN = 1'b1;
    sampleValid = 1'b1; sampleMa = 10'd200; sampleZacKohm = 12'd10; tickMs = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    evtSeen = 0;
  endtask

  // reset, enable with a healthy load and wait past the startup window
  task automatic bringUp();
    int tk, cy; bit hit;
    resetDut();
    hostEnable = 1'b1; loadPresent = 1'b1;
    waitStatus(1, 20, tk, cy, hit);
    expectRange("R1 power-up", int'(hit), 1, 1);
    waitTicks(int'(cfgInrushMs) + 2);
  endtask

  initial begin
    int tk, cy, lo; bit hit;
    smallCfg();
    resetDut();

    // reset state
    expectRange("R1 reset portEn", int'(portEn), 0, 0);
    expectRange("R1 reset status", int'(statusCode), 0, 0);
    expectRange("R12 reset event", int'(shutEvent), 0, 0);

    // R1 startup timing
    hostEnable = 1'b1; loadPresent = 1'b1;
    waitStatus(1, 10, tk, cy, hit);
    expectRange("R1 clocks to powered", cy, 1, 2);
    expectRange("R1 portEn high", int'(portEn), 1, 1);

    // R11 load flag low blocks power-up
    resetDut();
    hostEnable = 1'b1; loadPresent = 1'b0;
    waitStatus(1, 200, tk, cy, hit);
    expectRange("R11 no load no power", int'(hit), 0, 0);

    // R11 host enable low switches off, no pulse (R12)
    bringUp();
    hostEnable = 1'b0;
    waitStatus(0, 5, tk, cy, hit);
    expectRange("R11 host off", int'(hit), 1, 1);
    repeat (50) step();
    expectRange("R11 stays off", int'(statusCode), 0, 0);
    expectRange("R12 no pulse on host off", evtSeen, 0, 0);

    // R4 overload qualification sweep and cut boundary
    foreach (cfgSweep[i]) ;
    for (int t = 1; t <= 9; t += 4) begin
      smallCfg(); cfgOvlMs = 13'(t);
      bringUp();
      sampleMa = 10'd700;
      waitStatus(2, (t + 6) * TICK_DIV, tk, cy, hit);
      expectRange("R4 overload trips", int'(hit), 1, 1);
      lo = (t > 1) ? t - 1 : 0;
      expectRange("R4 ticks to overload", tk, lo, t + 2);
      repeat (3) step();
      expectRange("R12 one pulse per overload", evtSeen, 1, 1);
    end
    for (int c = 660; c <= 700; c += 20) begin
      smallCfg(); cfgCutMa = 10'(c);
      bringUp();
      sampleMa = 10'(c);
      waitStatus(2, 20 * TICK_DIV, tk, cy, hit);
      expectRange("R4 at cut keeps power", int'(hit), 0, 0);
      sampleMa = 10'(c + 1);
      waitStatus(2, 20 * TICK_DIV, tk, cy, hit);
      expectRange("R4 above cut trips", int'(hit), 1, 1);
    end

    // R2 inrush window masks overload
    smallCfg(); cfgInrushMs = 13'd8; cfgOvlMs = 13'd5;
    resetDut();
    sampleMa = 10'd740; hostEnable = 1'b1; loadPresent = 1'b1;
    waitStatus(2, 40 * TICK_DIV, tk, cy, hit);
    expectRange("R2 ticks inrush plus overload", tk, 12, 15);

    // R3 inrush ceiling
    smallCfg(); cfgInrushMs = 13'd20;
    resetDut();
    sampleMa = 10'd751; hostEnable = 1'b1; loadPresent = 1'b1;
    waitStatus(2, 20, tk, cy, hit);
    expectRange("R3 clocks above limit", cy, 1, 4);

    // R5 one clean sample restarts qualification
    smallCfg(); cfgOvlMs = 13'd6;
    bringUp();
    sampleMa = 10'd700;
    waitTicks(4);
    expectRange("R5 not yet tripped", int'(statusCode), 1, 1);
    sampleMa = 10'd200; step(); sampleMa = 10'd700;
    waitStatus(2, 20 * TICK_DIV, tk, cy, hit);
    expectRange("R5 full time after restart", tk, 5, 8);

    // R6 DC no-load sweep, minimum 7.5 mA
    for (int m = 0; m <= 10; m++) begin
      smallCfg();
      bringUp();
      sampleMa = 10'(m);
      waitStatus(3, 12 * TICK_DIV, tk, cy, hit);
      expectRange("R6 no-load decision", int'(hit), (2 * m < 15) ? 1 : 0, (2 * m < 15) ? 1 : 0);
      if (hit) expectRange("R6 ticks to no-load", tk, 5, 8);
    end

    // R7 AC mode impedance sweep with zero current
    for (int z = 0; z < 5; z++) begin
      int zv;
      zv = (z == 0) ? 10 : (z == 1) ? 27 : (z == 2) ? 1980 : (z == 3) ? 1981 : 3000;
      smallCfg(); cfgAcMode = 1'b1;
      bringUp();
      sampleMa = 10'd0; sampleZacKohm = 12'(zv);
      waitStatus(3, 12 * TICK_DIV, tk, cy, hit);
      expectRange("R7 AC no-load decision", int'(hit), (zv > 1980) ? 1 : 0, (zv > 1980) ? 1 : 0);
    end

    // R8 overload recovery sweep
    for (int r = 5; r <= 12; r += 7) begin
      smallCfg(); cfgOvlRecMs = 13'(r);
      bringUp();
      sampleMa = 10'd700;
      waitStatus(2, 40 * TICK_DIV, tk, cy, hit);
      waitStatus(1, (r + 6) * TICK_DIV, tk, cy, hit);
      expectRange("R8 overload retry ticks", tk, r - 1, r + 2);
    end

    // R9 no-load recovery sweep
    for (int r = 3; r <= 9; r += 6) begin
      smallCfg(); cfgUdlRecMs = 13'(r);
      bringUp();
      sampleMa = 10'd2;
      waitStatus(3, 40 * TICK_DIV, tk, cy, hit);
      repeat (3) step();
      expectRange("R12 one pulse per no-load", evtSeen, 1, 1);
      waitStatus(1, (r + 6) * TICK_DIV, tk, cy, hit);
      expectRange("R9 no-load retry ticks", tk, r - 1, r + 2);
    end

    // defaults: R4, R8, R6, R9
    cfgAcMode = 1'b0; cfgCutMa = 10'(DEF_CUT_MA); cfgLimMa = 10'(DEF_LIM_MA);
    cfgMinHalfMa = 11'(DEF_MIN_HALF_MA); cfgZacCutKohm = 12'(DEF_ZAC_KOHM);
    cfgOvlMs = 13'(DEF_OVL_MS); cfgHoldMs = 13'(DEF_HOLD_MS);
    cfgInrushMs = 13'(DEF_INRUSH_MS); cfgOvlRecMs = 13'(DEF_OVLREC_MS);
    cfgUdlRecMs = 13'(DEF_UDLREC_MS);
    bringUp();
    sampleMa = 10'd700;
    waitStatus(2, 60 * TICK_DIV, tk, cy, hit);
    expectRange("R4 default overload ticks", tk, 49, 52);
    sampleMa = 10'd200;
    waitStatus(1, 5010 * TICK_DIV, tk, cy, hit);
    expectRange("R8 default overload retry", tk, 4999, 5002);
    waitTicks(DEF_INRUSH_MS + 2);
    sampleMa = 10'd3;
    waitStatus(3, 360 * TICK_DIV, tk, cy, hit);
    expectRange("R6 default no-load ticks", tk, 349, 352);
    waitStatus(1, 1010 * TICK_DIV, tk, cy, hit);
    expectRange("R9 default no-load retry", tk, 999, 1002);

    // R10 global disable from powered and from a shutdown state
    smallCfg();
    bringUp();
    @(negedge clk); disableN = 1'b0; #1;
    expectRange("R10 portEn drops at once", int'(portEn), 0, 0);
    step();
    expectRange("R10 status off", int'(statusCode), 0, 0);
    repeat (40) step();
    expectRange("R10 held off", int'(statusCode), 0, 0);
    expectRange("R10 portEn held low", int'(portEn), 0, 0);
    disableN = 1'b1;
    waitStatus(1, 10, tk, cy, hit);
    expectRange("R10 release powers again", int'(hit), 1, 1);
    waitTicks(5);
    sampleMa = 10'd700;
    waitStatus(2, 20 * TICK_DIV, tk, cy, hit);
    disableN = 1'b0;
    step(); step();
    expectRange("R10 overload-off to off", int'(statusCode), 0, 0);

    finishRun();
  end

  int cfgSweep[1];

endmodule